// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block serialises one 32-bit command word into a management frame on an Ethernet PHY's MDC/MDIO pair. Software places the whole frame (start code, opcode, PHY address, register address, turnaround and data) in a single frame register. Writing that register starts the transfer. The controller first sends a 32-bit preamble of ones and then the command word, most significant bit first, with MDC derived from the bus clock.

On a read the controller releases MDIO for the turnaround and data bits. It samples the PHY's reply on each rising MDC edge and shifts the 16 returned bits into the low half of the frame register, where software collects them. Completion is reported through a sticky event flag that software clears by writing a one. A mask bit routes the flag to a single interrupt output. A self-clearing soft-reset bit returns the block to its idle state.

Registers are selected by a 3-bit word address: 0 control, 1 event, 2 mask, 3 speed, 4 frame.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After a frame starts, MDIO carries 32 ones and then frame register bits 31 down to 0. MDIO changes only after a falling MDC edge, so each bit is stable at the rising edge that follows.
- R2: The speed register holds a divider field D in bits 6:1. While a frame runs, MDC has a period of 2×D bus clocks. MDC is low whenever no frame is running.
- R3: When D is zero, a write to the frame register starts no frame. MDC stays low and the completion flag stays clear.
- R4: When frame bits 29:28 are 2'b10 (read), mdio_oe is low for the two turnaround bits and the 16 data bits. The 16 values sampled at the last 16 rising MDC edges, first sample in bit 15, replace frame bits 15:0. Bits 31:16 are unchanged.
- R5: For any other opcode, mdio_oe is high for all 64 bit times and the frame register keeps its written value.
- R6: Event bit 0 is set when the 64th bit time ends and stays set. A write with bit 0 set clears it, including a write of all ones. A write with bit 0 clear leaves it unchanged.
- R7: irq equals event bit 0 AND mask bit 0. With the mask at 0, irq stays low.
- R8: A frame-register write while a frame is running is ignored. The running frame and the register contents are unchanged.
- R9: Writing 1 to control bit 0 makes that bit read 1 for RST_CYC cycles, after which it clears itself. The frame is aborted, and the event, mask, speed and frame registers read 0 afterwards.
- R10: After rst_n, every register reads 0, and mdc, mdio_oe and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the pad |
| irq | output | 1 | Masked completion interrupt |

## Verification
Each pattern targets one kind of fault.

- **Write frame, divider 2, mixed data bits:** the preamble/command ordering and the constant output enable show whether bits are reversed, dropped or released too early.
- **Read frame, divider 3, reply different from the written low half:** checks that the release begins exactly at the turnaround and that the reply lands in place in the correct bit order. It also checks that the MDC period follows the divider rather than a fixed value.
- **Overlapping write, zero divider and mid-frame soft reset:** these separate a correctly guarded start condition from one that restarts, corrupts or hangs the frame.

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int RST_CYC = 4,
  parameter int DIVW    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        irq
);
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam logic [2:0] A_CTL = 3'd0, A_EVT = 3'd1, A_MSK = 3'd2,
                         A_SPD = 3'd3, A_FRM = 3'd4;

  logic [31:0]     frame_q;
  logic            done_q, mask_q, busy_q;
  logic [DIVW-1:0] div_q, cnt_q;
  logic [5:0]      bitn_q;
  logic [RCW-1:0]  rcnt_q;

  wire srst   = rcnt_q != '0;
  wire wr_ok  = reg_we && !srst;
  wire is_rd  = frame_q[29:28] == 2'b10;
  wire tick   = busy_q && (cnt_q == div_q - DIVW'(1));
  wire start  = wr_ok && reg_addr == A_FRM && !busy_q && div_q != '0;
  wire finish = tick && mdc && bitn_q == 6'd63;
  wire ev_clr = wr_ok && reg_addr == A_EVT && reg_wdata[0];

  assign mdio_o  = busy_q && (bitn_q < 6'd32 || frame_q[~bitn_q[4:0]]);
  assign mdio_oe = busy_q && !(is_rd && bitn_q >= 6'd46);
  assign irq     = done_q && mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q  <= '0;
      frame_q <= '0;
      done_q  <= 1'b0;
      mask_q  <= 1'b0;
      div_q   <= '0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      bitn_q  <= '0;
      mdc     <= 1'b0;
    end else begin
      if (srst)
        rcnt_q <= rcnt_q - RCW'(1);
      else if (reg_we && reg_addr == A_CTL && reg_wdata[0])
        rcnt_q <= RCW'(RST_CYC);

      if (srst) begin
        frame_q <= '0;
        done_q  <= 1'b0;
        mask_q  <= 1'b0;
        div_q   <= '0;
        busy_q  <= 1'b0;
        cnt_q   <= '0;
        bitn_q  <= '0;
        mdc     <= 1'b0;
      end else begin
        if (wr_ok && reg_addr == A_MSK) mask_q <= reg_wdata[0];
        if (wr_ok && reg_addr == A_SPD) div_q  <= reg_wdata[DIVW:1];

        if (start) begin
          frame_q <= reg_wdata;
          busy_q  <= 1'b1;
          bitn_q  <= '0;
          cnt_q   <= '0;
          mdc     <= 1'b0;
        end else if (busy_q) begin
          if (tick) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
            if (!mdc) begin
              if (is_rd && bitn_q >= 6'd48)
                frame_q[15:0] <= {frame_q[14:0], mdio_i};
            end else if (bitn_q == 6'd63) begin
              busy_q <= 1'b0;
            end else begin
              bitn_q <= bitn_q + 6'd1;
            end
          end else begin
            cnt_q <= cnt_q + DIVW'(1);
          end
        end

        if (finish)      done_q <= 1'b1;
        else if (ev_clr) done_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = {31'b0, srst};
      A_EVT:   reg_rdata = {31'b0, done_q};
      A_MSK:   reg_rdata = {31'b0, mask_q};
      A_SPD:   reg_rdata = {{(31-DIVW){1'b0}}, div_q, 1'b0};
      A_FRM:   reg_rdata = frame_q;
      default: reg_rdata = '0;
    endcase
  end

  // R2: MDC idles low
  a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc);
  // R1: preamble bits are ones
  a_r1_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && bitn_q < 6'd32 |-> mdio_o && mdio_oe);
  // R3: a zero divider never starts a frame
  a_r3_no_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && div_q == '0 |=> !busy_q);
  // R6: completion flag is sticky
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !ev_clr && !srst |=> done_q);
  // R7: interrupt needs the mask
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q && done_q);
  // R8: command half holds while a frame runs
  a_r8_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !srst |=> $stable(frame_q[31:16]));
  // R9: soft reset leaves the block idle
  a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !busy_q && !done_q);
endmodule

// File: tb/tb_mdio_frame_ctrl.sv
module tb_mdio_frame_ctrl;
  logic clk = 0, rst_n = 0, reg_we = 0, mdio_i = 1;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, irq;

  mdio_frame_ctrl dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq));

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0, rises = 0, last_rise = 0, per = 0;
  logic [63:0] cap = 0, capoe = 0;
  logic [15:0] reply = 0;
  bit ended = 0;

  always @(posedge clk) cyc = cyc + 1;

  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_o};
    capoe = {capoe[62:0], mdio_oe};
    if (rises > 0) per = cyc - last_rise;
    last_rise = cyc;
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises < 64) mdio_i = reply[63 - rises];
    else mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, v);
      if (v[0]) begin ok = 1; break; end
    end
  endtask

  task automatic start_frame(input logic [31:0] cmd, input logic [15:0] rep);
    wr(3'd1, 32'h1);
    reply = rep; rises = 0; per = 0; cap = 0; capoe = 0;
    wr(3'd4, cmd);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check(v == 0, "R10 register reset value", 64'(v), 64'h0);
    end
    check({mdc, mdio_oe, irq} == 3'b000, "R10 pins idle", 64'({mdc, mdio_oe, irq}), 64'h0);
  endtask

  task automatic t_write_frame;
    logic [31:0] cmd, v; bit ok;
    cmd = 32'h5002_0000 | (32'd5 << 23) | (32'd3 << 18) | 32'hA5C3;
    wr(3'd3, 32'd2 << 1);
    start_frame(cmd, 16'h0);
    wait_done(ok);
    check(ok, "R6 completion flag set after write frame", 64'(ok), 64'h1);
    check(cap == {32'hFFFF_FFFF, cmd}, "R1 preamble and command order", cap, {32'hFFFF_FFFF, cmd});
    check(capoe == '1, "R5 MDIO driven for whole write", capoe, '1);
    check(rises == 64, "R1 bit count", 64'(rises), 64'd64);
    check(per == 4, "R2 MDC period for divider 2", 64'(per), 64'd4);
    check(mdc == 0, "R2 MDC low after frame", 64'(mdc), 64'h0);
    rd(3'd4, v);
    check(v == cmd, "R5 frame register unchanged by write", 64'(v), 64'(cmd));
    check(irq == 0, "R7 irq low with mask 0", 64'(irq), 64'h0);
  endtask

  task automatic t_read_frame;
    logic [31:0] cmd, v; logic [63:0] expoe; bit ok;
    cmd = 32'h6002_0000 | (32'd1 << 23) | (32'd2 << 18) | 32'h1234;
    wr(3'd3, 32'd3 << 1);
    start_frame(cmd, 16'hBEEF);
    wait_done(ok);
    check(ok, "R6 completion flag set after read frame", 64'(ok), 64'h1);
    check(cap[63:18] == {32'hFFFF_FFFF, cmd[31:18]}, "R1 read header bits", 64'(cap[63:18]),
          64'({32'hFFFF_FFFF, cmd[31:18]}));
    expoe = {{46{1'b1}}, 18'b0};
    check(capoe == expoe, "R4 MDIO released at turnaround and data", capoe, expoe);
    check(per == 6, "R2 MDC period for divider 3", 64'(per), 64'd6);
    rd(3'd4, v);
    check(v == {cmd[31:16], 16'hBEEF}, "R4 reply in low half", 64'(v), 64'({cmd[31:16], 16'hBEEF}));
  endtask

  task automatic t_event_irq;
    logic [31:0] v; bit ok;
    wr(3'd1, 32'h0);
    rd(3'd1, v);
    check(v[0] == 1, "R6 write 0 keeps flag", 64'(v[0]), 64'h1);
    wr(3'd2, 32'h1);
    check(irq == 1, "R7 irq with flag and mask", 64'(irq), 64'h1);
    wr(3'd2, 32'h0);
    check(irq == 0, "R7 irq blocked by mask 0", 64'(irq), 64'h0);
    wr(3'd2, 32'h1);
    wr(3'd1, 32'h1);
    rd(3'd1, v);
    check(v[0] == 0, "R6 write 1 clears flag", 64'(v[0]), 64'h0);
    check(irq == 0, "R7 irq drops with flag", 64'(irq), 64'h0);
    wr(3'd3, 32'd2 << 1);
    start_frame(32'h5002_0000, 16'h0);
    wait_done(ok);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v);
    check(v[0] == 0, "R6 all ones clears flag", 64'(v[0]), 64'h0);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_busy_write;
    logic [31:0] a, b, v; bit ok;
    a = 32'h5002_0000 | (32'd9 << 23) | 32'h0F0F;
    b = 32'h6002_0000 | (32'd3 << 23) | 32'h7777;
    start_frame(a, 16'h0);
    repeat (50) @(negedge clk);
    wr(3'd4, b);
    wait_done(ok);
    check(cap == {32'hFFFF_FFFF, a}, "R8 running frame unaffected", cap, {32'hFFFF_FFFF, a});
    rd(3'd4, v);
    check(v == a, "R8 frame register keeps first word", 64'(v), 64'(a));
  endtask

  task automatic t_zero_speed;
    logic [31:0] v;
    wr(3'd3, 32'h0);
    start_frame(32'h5002_0000 | 32'h00FF, 16'h0);
    repeat (300) @(negedge clk);
    check(rises == 0, "R3 no MDC edge with divider 0", 64'(rises), 64'h0);
    rd(3'd1, v);
    check(v[0] == 0, "R3 no completion with divider 0", 64'(v[0]), 64'h0);
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    wr(3'd3, 32'd2 << 1);
    wr(3'd2, 32'h1);
    start_frame(32'h5002_0000 | 32'h4321, 16'h0);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'h1);
    rd(3'd0, v);
    check(v[0] == 1, "R9 reset bit reads 1 while active", 64'(v[0]), 64'h1);
    repeat (10) @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check(v == 0, "R9 registers cleared and bit self-clears", 64'(v), 64'h0);
    end
    check({mdc, mdio_oe, irq} == 3'b000, "R9 frame aborted", 64'({mdc, mdio_oe, irq}), 64'h0);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_write_frame;
    t_read_frame;
    t_event_irq;
    t_busy_write;
    t_zero_speed;
    t_soft_reset;
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule